// File: doc/BRIEF.md
# DALI Backward-Frame Controller

This block is the slave-side transmit controller of a DALI lighting interface. Software reaches it through a small register port. A separate receiver decodes the incoming forward frame and signals it with a one-cycle strobe. Once that strobe has been seen, software loads an answer byte and issues a send command. The controller then drives the byte onto the bus output as a biphase-coded backward frame and reports completion through a status flag and an interrupt line.

A test mode sends the answer byte without waiting for any forward frame, and a restart command repeats the send. In the listening state the controller also watches the bus input and flags an interface failure when the line stays low for two bit periods. A halt input freezes every register. Clearing the enable bit returns the sequencer to its idle state.

Top module: `dali_bwd_ctrl`

## Requirements
- R1: After reset the bus output is high, the interrupt is low and the status register (address 1) reads 0. The bus output is high whenever no frame is being sent.
- R2: A frame consists of a start bit of 1, then the 8 data bits MSB first, then four idle-high half-bit slots. Each half-bit slot lasts HALF_CYC clocks. A 1 is sent as low then high, and a 0 as high then low.
- R3: A send command is a control write (address 0) with bit0 enable, bit2 request and bit3 restart all set and bit1 clear. It is ignored when no forward-frame strobe has arrived since the listening state was entered.
- R4: After a backward frame, a further send command is ignored until a new forward-frame strobe arrives.
- R5: At the end of every frame, status bit0 is set. The irq output equals status bit0 AND control bit4. Reading the status register clears it.
- R6: A control write with bit0 and bit1 set, made while bit1 was previously clear, sends the data register (address 2) with no forward frame.
- R7: While bit1 is set and no frame is in flight, a control write with bits 0, 1 and 3 set sends the data register again.
- R8: In the listening state, a bus input that is low for 4*HALF_CYC consecutive clocks sets status bit1. One clock fewer does not set it. A status read clears it.
- R9: A low bus input while a frame is being sent does not set status bit1.
- R10: Clearing control bit0 aborts any frame in flight, forces the bus output high and discards a forward frame already received.
- R11: While halt is high, the bus output, the flags and the sequencer hold their values, and a status read does not clear the flags. The frame resumes when halt falls.
- R12: With control bit4 clear, the irq output stays low even though status bit0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt | input | 1 | Freeze all state while high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a status read clears the flags) |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| fwd_rcvd | input | 1 | One-cycle strobe: forward frame received |
| bus_in | input | 1 | Sampled bus level |
| bus_out | output | 1 | Bus drive level, idle high |
| irq | output | 1 | End-of-frame interrupt |

## Verification
The hardest situations to reach are the ones where the controller must refuse to act. Examples are a second send right after a backward frame, a send after a disable and re-enable that has discarded a pending forward frame, and a low bus level that arrives mid-frame rather than while listening. The bench reaches each of them with a scripted sequence of register writes and strobes, and then counts falling edges on the bus output over a long window to prove that no frame started. The failure timer is tested at its exact boundary, with one clock below and one clock at the limit. A halt is inserted in the middle of a frame to show that the output freezes and then resumes.

// File: rtl/dali_pkg.sv
package dali_pkg;

    localparam int FRAME_BITS = 9;                   // start bit + 8 data bits
    localparam int CODED_SLOTS = 2 * FRAME_BITS;     // biphase halves carrying data
    localparam int HALF_SLOTS = CODED_SLOTS + 4;     // plus two idle stop bits

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_LISTEN = 2'd1,
        ST_SEND   = 2'd2
    } seq_e;

    typedef struct packed {
        logic irq_en;
        logic forced;
        logic enable;
    } ctrl_t;

    typedef struct packed {
        logic err;
        logic eot;
    } flags_t;

    // Level of one biphase half: a 1 is low then high, a 0 is high then low.
    function automatic logic biphase_level(input logic bitv, input logic second_half);
        return second_half ? bitv : ~bitv;
    endfunction

endpackage

// File: rtl/dali_biphase_tx.sv
module dali_biphase_tx
    import dali_pkg::*;
#(
    parameter int HALF_CYC = 52083
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hold,
    input  logic       abort,
    input  logic       start,
    input  logic [7:0] data,
    output logic       busy,
    output logic       line,
    output logic       done
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int SW = $clog2(HALF_SLOTS + 1);
    localparam logic [CW-1:0] CYC_END = CW'(HALF_CYC - 1);
    localparam logic [SW-1:0] LAST_SLOT = SW'(HALF_SLOTS - 1);
    localparam logic [SW-1:0] CODED_END = SW'(CODED_SLOTS);

    logic [CW-1:0]         cyc_q;
    logic [SW-1:0]         slot_q;
    logic [FRAME_BITS-1:0] shreg_q;
    logic                  busy_q;
    logic                  half_end;

    assign half_end = busy_q && (cyc_q == CYC_END);
    assign done     = half_end && (slot_q == LAST_SLOT) && !hold && !abort;
    assign busy     = busy_q;
    assign line     = (busy_q && slot_q < CODED_END)
                    ? biphase_level(shreg_q[FRAME_BITS-1], slot_q[0]) : 1'b1;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy_q  <= 1'b0;
            cyc_q   <= '0;
            slot_q  <= '0;
            shreg_q <= '0;
        end else if (!hold) begin
            if (start) begin
                busy_q  <= 1'b1;
                cyc_q   <= '0;
                slot_q  <= '0;
                shreg_q <= {1'b1, data};
            end else if (busy_q) begin
                if (half_end) begin
                    cyc_q <= '0;
                    if (slot_q == LAST_SLOT) begin
                        busy_q <= 1'b0;
                    end else begin
                        slot_q <= slot_q + SW'(1);
                    end
                    if (slot_q[0]) begin
                        shreg_q <= {shreg_q[FRAME_BITS-2:0], 1'b0};
                    end
                end else begin
                    cyc_q <= cyc_q + CW'(1);
                end
            end
        end
    end

    // R2: every coded bit has a transition at its middle
    a_r2_mid_bit_edge: assert property (@(posedge clk) disable iff (rst)
        (busy_q && half_end && !slot_q[0] && slot_q < CODED_END && !hold && !abort && !start)
        |=> (line != $past(line)));

    // R2: a new frame is never loaded on top of one in flight
    a_r2_start_when_free: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q);

endmodule

// File: rtl/dali_low_watch.sv
module dali_low_watch #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic arm,
    input  logic level,
    output logic trip
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);
    localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign trip = arm && !hold && !level && (cnt_q == LIM_M1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!hold) begin
            if (!arm || level) begin
                cnt_q <= '0;
            end else if (cnt_q != LIM) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    // R8: a trip needs the line to have been low on the previous clock as well
    a_r8_low_before_trip: assert property (@(posedge clk) disable iff (rst)
        trip |-> $past(!level));

endmodule

// File: rtl/dali_bwd_ctrl.sv
module dali_bwd_ctrl
    import dali_pkg::*;
#(
    parameter int HALF_CYC = 52083
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       halt,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       fwd_rcvd,
    input  logic       bus_in,
    output logic       bus_out,
    output logic       irq
);
    localparam int FAIL_CYC = 4 * HALF_CYC;   // two bit periods

    ctrl_t      ctrl_q;
    flags_t     flags_q;
    seq_e       st_q;
    logic [7:0] data_q;
    logic       fwd_seen_q;
    logic       kick_q;

    logic wr_ctrl, rd_stat, go_norm, go_force, go;
    logic tx_busy, tx_done, trip;

    assign wr_ctrl = reg_wr && !halt && (reg_addr == ADDR_CTRL);
    assign rd_stat = reg_rd && !halt && (reg_addr == ADDR_STAT);

    assign go_norm  = wr_ctrl && reg_wdata[0] && !reg_wdata[1] && reg_wdata[2]
                   && reg_wdata[3] && !ctrl_q.forced && (st_q == ST_LISTEN) && fwd_seen_q;
    assign go_force = !halt && ctrl_q.enable && (st_q == ST_LISTEN) && kick_q;
    assign go       = go_norm || go_force;

    dali_biphase_tx #(.HALF_CYC(HALF_CYC)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .hold  (halt),
        .abort (!ctrl_q.enable),
        .start (go),
        .data  (data_q),
        .busy  (tx_busy),
        .line  (bus_out),
        .done  (tx_done)
    );

    dali_low_watch #(.LIMIT(FAIL_CYC)) u_watch (
        .clk   (clk),
        .rst   (rst),
        .hold  (halt),
        .arm   (st_q == ST_LISTEN),
        .level (bus_in),
        .trip  (trip)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            flags_q    <= '0;
            st_q       <= ST_OFF;
            data_q     <= '0;
            fwd_seen_q <= 1'b0;
            kick_q     <= 1'b0;
        end else if (!halt) begin
            if (wr_ctrl) begin
                ctrl_q <= '{irq_en: reg_wdata[4], forced: reg_wdata[1], enable: reg_wdata[0]};
            end
            if (reg_wr && reg_addr == ADDR_DATA) begin
                data_q <= reg_wdata;
            end

            if (wr_ctrl && reg_wdata[0] && reg_wdata[1]
                && (!ctrl_q.forced || (reg_wdata[3] && st_q != ST_SEND))) begin
                kick_q <= 1'b1;
            end else if (go_force || !ctrl_q.enable || (wr_ctrl && !(reg_wdata[0] && reg_wdata[1]))) begin
                kick_q <= 1'b0;
            end

            if (st_q != ST_LISTEN || go) begin
                fwd_seen_q <= 1'b0;
            end else if (fwd_rcvd) begin
                fwd_seen_q <= 1'b1;
            end

            if (!ctrl_q.enable) begin
                st_q <= ST_OFF;
            end else begin
                unique case (st_q)
                    ST_OFF:    st_q <= ST_LISTEN;
                    ST_LISTEN: if (go) st_q <= ST_SEND;
                    ST_SEND:   if (tx_done) st_q <= ST_LISTEN;
                    default:   st_q <= ST_OFF;
                endcase
            end

            flags_q.eot <= tx_done || (flags_q.eot && !rd_stat);
            flags_q.err <= trip || (flags_q.err && !rd_stat);
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = {3'b000, ctrl_q.irq_en, 2'b00, ctrl_q.forced, ctrl_q.enable};
            ADDR_STAT: reg_rdata = {6'b000000, flags_q.err, flags_q.eot};
            ADDR_DATA: reg_rdata = data_q;
            default:   reg_rdata = 8'h00;
        endcase
    end

    assign irq = flags_q.eot && ctrl_q.irq_en;

    // R1: the line is idle high outside the send state
    a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_SEND) |-> bus_out);

    // R4: a normal send always consumed a fresh forward frame
    a_r4_fresh_forward: assert property (@(posedge clk) disable iff (rst)
        ($rose(st_q == ST_SEND) && !ctrl_q.forced) |-> $past(fwd_seen_q));

    // R5: the end flag rises only as a frame finishes
    a_r5_eot_after_send: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q.eot) |-> $past(st_q == ST_SEND));

    // R9: failure flag rises only from the listening state
    a_r9_err_only_listen: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q.err) |-> $past(st_q == ST_LISTEN));

    // R10: disabled means idle sequencer and idle shifter
    a_r10_disable_idle: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.enable && !halt) |=> (st_q == ST_OFF && !tx_busy));

    // R11: halt freezes the observable state
    a_r11_halt_freeze: assert property (@(posedge clk) disable iff (rst)
        halt |=> ($stable(st_q) && $stable(bus_out) && $stable(flags_q)));

endmodule

// File: tb/tb_dali_bwd_ctrl.sv
module tb_dali_bwd_ctrl;
    localparam int H = 8;
    localparam int SLOTS = 22;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       halt = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       fwd_rcvd = 1'b0;
    logic       bus_in = 1'b1;
    logic       bus_out;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int falls = 0;
    int frames = 0;
    logic exp_q[$];

    always #4 clk = ~clk;

    dali_bwd_ctrl #(.HALF_CYC(H)) dut (
        .clk(clk), .rst(rst), .halt(halt),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fwd_rcvd(fwd_rcvd), .bus_in(bus_in), .bus_out(bus_out), .irq(irq)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse_fwd();
        @(negedge clk);
        fwd_rcvd = 1'b1;
        @(negedge clk);
        fwd_rcvd = 1'b0;
    endtask

    // Driver: push the 22 expected half-slot levels of a frame
    task automatic send_expect(input logic [7:0] d);
        logic [8:0] fr;
        fr = {1'b1, d};
        for (int k = 8; k >= 0; k--) begin
            exp_q.push_back(~fr[k]);
            exp_q.push_back(fr[k]);
        end
        for (int k = 0; k < 4; k++) exp_q.push_back(1'b1);
    endtask

    task automatic wait_frames(input int n);
        for (int i = 0; i < 1000 && frames < n; i++) @(negedge clk);
        chk(frames == n, "R2 frame count", frames, n);
        repeat (8) @(negedge clk);
    endtask

    // Monitor: sample the middle of each half slot and compare with the queue
    always begin
        @(negedge bus_out);
        falls++;
        if (exp_q.size() >= SLOTS) begin
            repeat (H / 2) @(negedge clk);
            for (int i = 0; i < SLOTS; i++) begin
                logic e;
                e = exp_q.pop_front();
                chk(bus_out === e, "R2 half-slot level", int'(bus_out), int'(e));
                if (i < SLOTS - 1) repeat (H) @(negedge clk);
            end
            frames++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int f0;
        int mism;
        logic b;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(bus_out === 1'b1, "R1 bus idle", int'(bus_out), 1);
        chk(irq === 1'b0, "R1 irq low", int'(irq), 0);
        reg_read(2'd1, v);
        chk(v == 8'h00, "R1 status", v, 0);

        // R3: request with no forward frame
        reg_write(2'd2, 8'hA5);
        reg_write(2'd0, 8'h11);
        f0 = falls;
        reg_write(2'd0, 8'h1D);
        repeat (200) @(negedge clk);
        chk(falls == f0, "R3 no frame without forward", falls, f0);
        reg_read(2'd1, v);
        chk(v == 8'h00, "R3 status", v, 0);

        // R2 / R5: normal frame after a forward frame
        pulse_fwd();
        send_expect(8'hA5);
        reg_write(2'd0, 8'h1D);
        wait_frames(1);
        chk(irq === 1'b1, "R5 irq raised", int'(irq), 1);
        reg_read(2'd1, v);
        chk(v == 8'h01, "R5 eot flag", v, 1);
        chk(irq === 1'b0, "R5 irq cleared by read", int'(irq), 0);

        // R4: no back-to-back backward frames
        f0 = falls;
        reg_write(2'd0, 8'h1D);
        repeat (200) @(negedge clk);
        chk(falls == f0, "R4 second send ignored", falls, f0);
        reg_read(2'd1, v);
        chk(v == 8'h00, "R4 status", v, 0);

        // R12: fresh forward, irq masked
        pulse_fwd();
        reg_write(2'd2, 8'h3C);
        send_expect(8'h3C);
        reg_write(2'd0, 8'h0D);
        wait_frames(2);
        chk(irq === 1'b0, "R12 irq masked", int'(irq), 0);
        reg_read(2'd1, v);
        chk(v == 8'h01, "R12 eot still flagged", v, 1);

        // R8: failure timer boundary
        @(negedge clk); bus_in = 1'b0;
        repeat (4 * H - 1) @(negedge clk);
        bus_in = 1'b1;
        repeat (2) @(negedge clk);
        reg_read(2'd1, v);
        chk(v == 8'h00, "R8 one clock short", v, 0);
        @(negedge clk); bus_in = 1'b0;
        repeat (4 * H) @(negedge clk);
        bus_in = 1'b1;
        repeat (2) @(negedge clk);
        reg_read(2'd1, v);
        chk(v == 8'h02, "R8 failure flagged", v, 2);
        reg_read(2'd1, v);
        chk(v == 8'h00, "R8 cleared by read", v, 0);

        // R6: forced send, no forward frame
        reg_write(2'd0, 8'h00);
        reg_write(2'd2, 8'h81);
        send_expect(8'h81);
        reg_write(2'd0, 8'h13);
        wait_frames(3);
        chk(irq === 1'b1, "R6 forced frame irq", int'(irq), 1);
        reg_read(2'd1, v);
        chk(v == 8'h01, "R6 status", v, 1);

        // R7 restart, with R9 low bus during the frame
        send_expect(8'h81);
        reg_write(2'd0, 8'h1B);
        repeat (20) @(negedge clk);
        bus_in = 1'b0;
        repeat (6 * H) @(negedge clk);
        bus_in = 1'b1;
        wait_frames(4);
        reg_read(2'd1, v);
        chk(v == 8'h01, "R7 restart done, R9 no failure", v, 1);

        // R10: abort a forced frame in flight
        reg_write(2'd0, 8'h1B);
        repeat (40) @(negedge clk);
        reg_write(2'd0, 8'h00);
        repeat (2) @(negedge clk);
        f0 = falls;
        chk(bus_out === 1'b1, "R10 bus high after disable", int'(bus_out), 1);
        repeat (200) @(negedge clk);
        chk(falls == f0, "R10 no activity", falls, f0);
        reg_read(2'd1, v);
        chk(v == 8'h00, "R10 no eot on abort", v, 0);

        // R10: a pending forward frame is dropped by disable
        reg_write(2'd0, 8'h11);
        repeat (2) @(negedge clk);
        pulse_fwd();
        reg_write(2'd0, 8'h00);
        reg_write(2'd0, 8'h11);
        repeat (2) @(negedge clk);
        f0 = falls;
        reg_write(2'd0, 8'h1D);
        repeat (200) @(negedge clk);
        chk(falls == f0, "R10 forward discarded", falls, f0);

        // R11: halt in the middle of a frame
        pulse_fwd();
        reg_write(2'd2, 8'h55);
        reg_write(2'd0, 8'h1D);
        repeat (50) @(negedge clk);
        halt = 1'b1;
        b = bus_out;
        mism = 0;
        repeat (40) begin
            @(negedge clk);
            if (bus_out !== b || irq !== 1'b0) mism++;
        end
        chk(mism == 0, "R11 frozen during halt", mism, 0);
        halt = 1'b0;
        for (int i = 0; i < 400 && irq !== 1'b1; i++) @(negedge clk);
        chk(irq === 1'b1, "R11 frame resumes", int'(irq), 1);
        @(negedge clk); halt = 1'b1;
        reg_read(2'd1, v);
        chk(v == 8'h01, "R11 read during halt", v, 1);
        @(negedge clk); halt = 1'b0;
        reg_read(2'd1, v);
        chk(v == 8'h01, "R11 flag kept over halted read", v, 1);
        reg_read(2'd1, v);
        chk(v == 8'h00, "R5 cleared after halt", v, 0);

        chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule